// File: doc/BRIEF.md
# Speculative Result Buffer with In-Order Retirement

This block sits between instruction issue and the architectural state of an out-of-order core. Each issued instruction claims one slot of a circular buffer, in program order, and the slot index becomes that instruction's rename tag. Execution units report completion on a shared result bus that carries this tag. The bus also carries the value, an auxiliary address, a misprediction flag and an exception code. Until an instruction retires, operand lookups for its destination register are served from its slot.

Retirement takes place only at the oldest slot, and only once that slot has a result. A register-writing instruction updates the register file at that point, and a store is released to memory at that point. A mispredicted branch at the oldest slot retires, discards everything younger and redirects fetch to the correct target. An instruction with a recorded exception code at the oldest slot is not retired. Instead the whole buffer is discarded and the faulting PC and code are reported, so execution can resume from that instruction.

Top module: `spec_rob`

## Requirements
- R1: `iss_ready` is high only when `iss_rs_free` is high and fewer than DEPTH slots are occupied. Accepted issues receive slot tags that run 0, 1, 2, ... from reset and wrap modulo DEPTH.
- R2: A result-bus write sets its slot done and stores its value. A lookup of a register whose newest pending writer is done then returns `op_from_rob`=1, `op_ready`=1 and that value.
- R3: A lookup of a register whose newest pending writer is not done returns `op_from_rob`=1, `op_ready`=0 and the writer's tag. A register with no pending writer returns `op_from_rob`=0 and `op_ready`=1.
- R4: Retirement happens only from the oldest slot, one instruction per cycle, in issue order. A younger slot that finishes early waits for all older slots.
- R5: Kind codes 0 (ALU) and 1 (load) write `rf_wdata` to `rf_waddr` at retirement. Kind code 2 (store) instead raises `st_valid` with `st_addr` taken from the bus auxiliary field and `st_data` taken from the bus value. The register file and the store stream then match a sequential execution of the retired instructions.
- R6: When an older writer of a register retires while a younger writer of the same register is still pending, lookups of that register keep pointing at the younger writer. Once the last writer retires, lookups go to the register file.
- R7: A kind code 3 (branch) slot done with the misprediction flag set raises `flush` and `redirect_valid` at retirement, with `redirect_pc` equal to its auxiliary field. No younger slot then retires, the buffer is empty afterwards, all lookups return `op_from_rob`=0, and the next tag issued is 0.
- R8: A nonzero exception code stays in its slot until that slot is the oldest. It then raises `flush` and `exc_valid` with `exc_code` and `exc_pc` (the slot's PC), and produces no register write or store. Younger slots are discarded, and the next tag issued is 0.
- R9: In a cycle with `flush` high, `iss_ready` is low and no issue is accepted.
- R10: After reset the buffer is empty, no retirement output is active, and `rf_we` and `st_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_rs_free | input | 1 | A reservation station is available |
| iss_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| iss_dest | input | AREG_W | Destination register (kinds 0 and 1) |
| iss_pc | input | ADDR_W | Instruction PC |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_tag | output | IDX_W | Slot tag given to the current issue |
| rb_valid | input | 1 | Result bus write |
| rb_tag | input | IDX_W | Slot being completed |
| rb_value | input | DATA_W | Result or store data |
| rb_aux | input | ADDR_W | Store address or correct branch target |
| rb_mispredict | input | 1 | Branch resolved opposite to prediction |
| rb_exc | input | EXC_W | Exception code, 0 for none |
| op_reg | input | NUM_RD x AREG_W | Registers looked up |
| op_from_rob | output | NUM_RD | Operand comes from the buffer |
| op_ready | output | NUM_RD | Operand value is available |
| op_tag | output | NUM_RD x IDX_W | Tag to wait for |
| op_value | output | NUM_RD x DATA_W | Forwarded value |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | AREG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| st_valid | output | 1 | Store released to memory |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Discard all in-flight work |
| redirect_valid | output | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | output | ADDR_W | Correct branch successor |
| exc_valid | output | 1 | Precise exception taken |
| exc_code | output | EXC_W | Exception code |
| exc_pc | output | ADDR_W | PC of the faulting instruction |

## Verification
The assertions assume that the result bus only names slots that are occupied, and names each slot at most once between its issue and its retirement. The stimulus meets this by broadcasting only tags returned from accepted issues, each exactly once, and by sending no broadcast for slots it expects to be discarded by a flush. The assertions also assume that `iss_valid` is sampled against `iss_ready` in the same cycle. The driver therefore reads `iss_ready` and `iss_tag` before the clock edge that accepts the issue.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_LOAD   = 2'd1,
        K_STORE  = 2'd2,
        K_BRANCH = 2'd3
    } op_kind_e;

    function automatic logic kind_writes_reg(op_kind_e k);
        return (k == K_ALU) || (k == K_LOAD);
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_retire,
    input  logic             do_flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             is_full,
    output logic             is_empty
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } ptr_s;

    ptr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (do_flush) begin
            st_d.head = '0;
            st_d.tail = '0;
        end else begin
            if (do_retire) st_d.head = st_q.head + PTR_W'(1);
            if (do_alloc)  st_d.tail = st_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx = st_q.head[IDX_W-1:0];
    assign tail_idx = st_q.tail[IDX_W-1:0];
    assign is_empty = (st_q.head == st_q.tail);
    assign is_full  = (st_q.head[IDX_W] != st_q.tail[IDX_W]) &&
                      (st_q.head[IDX_W-1:0] == st_q.tail[IDX_W-1:0]);

endmodule

// File: rtl/rob_reg_status.sv
module rob_reg_status #(
    parameter int DEPTH = 8,
    parameter int AREGS = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AREG_W = $clog2(AREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_we,
    input  logic [AREG_W-1:0]            set_reg,
    input  logic [IDX_W-1:0]             set_tag,
    input  logic                         clr_we,
    input  logic [AREG_W-1:0]            clr_reg,
    input  logic [IDX_W-1:0]             clr_tag,
    input  logic                         wipe,
    output logic [AREGS-1:0]             busy,
    output logic [AREGS-1:0][IDX_W-1:0]  owner
);
    typedef struct packed {
        logic [AREGS-1:0]            busy;
        logic [AREGS-1:0][IDX_W-1:0] owner;
    } stat_s;

    stat_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wipe) begin
            st_d.busy = '0;
        end else begin
            // release only if the retiring slot is still the newest writer
            if (clr_we && st_q.busy[clr_reg] && (st_q.owner[clr_reg] == clr_tag))
                st_d.busy[clr_reg] = 1'b0;
            // a new writer in the same cycle wins over the release
            if (set_we) begin
                st_d.busy[set_reg]  = 1'b1;
                st_d.owner[set_reg] = set_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign owner = st_q.owner;

endmodule

// File: rtl/rob_src_lookup.sv
module rob_src_lookup #(
    parameter int DEPTH = 8,
    parameter int AREGS = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AREG_W = $clog2(AREGS)
) (
    input  logic [AREG_W-1:0]            src_reg,
    input  logic [AREGS-1:0]             busy,
    input  logic [AREGS-1:0][IDX_W-1:0]  owner,
    input  logic [DEPTH-1:0]             slot_done,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_value,
    output logic                         from_rob,
    output logic                         ready,
    output logic [IDX_W-1:0]             tag,
    output logic [DATA_W-1:0]            value
);
    always_comb begin
        from_rob = busy[src_reg];
        tag      = owner[src_reg];
        ready    = !from_rob || slot_done[tag];
        value    = from_rob ? slot_value[tag] : '0;
    end

endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int AREGS  = 16,
    parameter int EXC_W  = 4,
    parameter int NUM_RD = 2,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int AREG_W = $clog2(AREGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iss_valid,
    input  logic                          iss_rs_free,
    input  logic [1:0]                    iss_kind,
    input  logic [AREG_W-1:0]             iss_dest,
    input  logic [ADDR_W-1:0]             iss_pc,
    output logic                          iss_ready,
    output logic [IDX_W-1:0]              iss_tag,
    input  logic                          rb_valid,
    input  logic [IDX_W-1:0]              rb_tag,
    input  logic [DATA_W-1:0]             rb_value,
    input  logic [ADDR_W-1:0]             rb_aux,
    input  logic                          rb_mispredict,
    input  logic [EXC_W-1:0]              rb_exc,
    input  logic [NUM_RD-1:0][AREG_W-1:0] op_reg,
    output logic [NUM_RD-1:0]             op_from_rob,
    output logic [NUM_RD-1:0]             op_ready,
    output logic [NUM_RD-1:0][IDX_W-1:0]  op_tag,
    output logic [NUM_RD-1:0][DATA_W-1:0] op_value,
    output logic                          rf_we,
    output logic [AREG_W-1:0]             rf_waddr,
    output logic [DATA_W-1:0]             rf_wdata,
    output logic                          st_valid,
    output logic [ADDR_W-1:0]             st_addr,
    output logic [DATA_W-1:0]             st_data,
    output logic                          flush,
    output logic                          redirect_valid,
    output logic [ADDR_W-1:0]             redirect_pc,
    output logic                          exc_valid,
    output logic [EXC_W-1:0]              exc_code,
    output logic [ADDR_W-1:0]             exc_pc
);
    typedef struct packed {
        logic              valid;
        logic              done;
        op_kind_e          kind;
        logic [AREG_W-1:0] dest;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] aux;
        logic              mispred;
        logic [EXC_W-1:0]  exc;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
    } state_s;

    state_s st_d, st_q;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             buf_full, buf_empty;
    logic             do_alloc, do_retire, do_flush;
    logic             take_exc, take_redirect;
    slot_t            hd;
    op_kind_e         new_kind;

    logic [AREGS-1:0]             reg_busy;
    logic [AREGS-1:0][IDX_W-1:0]  reg_owner;
    logic [DEPTH-1:0]             slot_done;
    logic [DEPTH-1:0][DATA_W-1:0] slot_value;

    assign hd       = st_q.slots[head_idx];
    assign new_kind = op_kind_e'(iss_kind);

    // retirement decision at the oldest slot
    always_comb begin
        take_exc      = !buf_empty && hd.valid && hd.done && (hd.exc != '0);
        take_redirect = !buf_empty && hd.valid && hd.done && (hd.exc == '0) &&
                        (hd.kind == K_BRANCH) && hd.mispred;
        do_flush      = take_exc || take_redirect;
        do_retire     = !buf_empty && hd.valid && hd.done && !take_exc;
    end

    assign iss_ready = iss_rs_free && !buf_full && !do_flush;
    assign do_alloc  = iss_valid && iss_ready;
    assign iss_tag   = tail_idx;

    always_comb begin
        st_d = st_q;
        if (do_flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.slots[i].valid = 1'b0;
                st_d.slots[i].done  = 1'b0;
            end
        end else begin
            if (rb_valid && st_q.slots[rb_tag].valid) begin
                st_d.slots[rb_tag].done    = 1'b1;
                st_d.slots[rb_tag].value   = rb_value;
                st_d.slots[rb_tag].aux     = rb_aux;
                st_d.slots[rb_tag].mispred = rb_mispredict;
                st_d.slots[rb_tag].exc     = rb_exc;
            end
            if (do_retire) begin
                st_d.slots[head_idx].valid = 1'b0;
                st_d.slots[head_idx].done  = 1'b0;
            end
            if (do_alloc) begin
                st_d.slots[tail_idx].valid   = 1'b1;
                st_d.slots[tail_idx].done    = 1'b0;
                st_d.slots[tail_idx].kind    = new_kind;
                st_d.slots[tail_idx].dest    = iss_dest;
                st_d.slots[tail_idx].pc      = iss_pc;
                st_d.slots[tail_idx].mispred = 1'b0;
                st_d.slots[tail_idx].exc     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // retirement outputs
    assign rf_we          = do_retire && kind_writes_reg(hd.kind);
    assign rf_waddr       = hd.dest;
    assign rf_wdata       = hd.value;
    assign st_valid       = do_retire && (hd.kind == K_STORE);
    assign st_addr        = hd.aux;
    assign st_data        = hd.value;
    assign flush          = do_flush;
    assign redirect_valid = take_redirect;
    assign redirect_pc    = hd.aux;
    assign exc_valid      = take_exc;
    assign exc_code       = hd.exc;
    assign exc_pc         = hd.pc;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_alloc  (do_alloc),
        .do_retire (do_retire),
        .do_flush  (do_flush),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .is_full   (buf_full),
        .is_empty  (buf_empty)
    );

    rob_reg_status #(.DEPTH(DEPTH), .AREGS(AREGS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (do_alloc && kind_writes_reg(new_kind)),
        .set_reg (iss_dest),
        .set_tag (tail_idx),
        .clr_we  (rf_we),
        .clr_reg (hd.dest),
        .clr_tag (head_idx),
        .wipe    (do_flush),
        .busy    (reg_busy),
        .owner   (reg_owner)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_done[i]  = st_q.slots[i].valid && st_q.slots[i].done;
            slot_value[i] = st_q.slots[i].value;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rob_src_lookup #(.DEPTH(DEPTH), .AREGS(AREGS), .DATA_W(DATA_W)) u_lk (
            .src_reg    (op_reg[p]),
            .busy       (reg_busy),
            .owner      (reg_owner),
            .slot_done  (slot_done),
            .slot_value (slot_value),
            .from_rob   (op_from_rob[p]),
            .ready      (op_ready[p]),
            .tag        (op_tag[p]),
            .value      (op_value[p])
        );
    end

endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
    parameter int NUM_RD = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_ready,
    input logic              buf_full,
    input logic              buf_empty,
    input logic              flush,
    input logic              redirect_valid,
    input logic              exc_valid,
    input logic              rf_we,
    input logic              st_valid,
    input logic [NUM_RD-1:0] op_from_rob
);
    AST_NO_ISSUE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) buf_full |-> !iss_ready); // R1
    AST_RETIRE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (rf_we || st_valid) |-> !buf_empty); // R4
    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) !(rf_we && st_valid)); // R10
    AST_REDIRECT_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n) redirect_valid |-> flush); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> buf_empty); // R7
    AST_FLUSH_CLEARS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (op_from_rob == '0)); // R7
    AST_EXC_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> (flush && !rf_we && !st_valid)); // R8
    AST_FLUSH_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) flush |-> !iss_ready); // R9
endmodule

bind spec_rob spec_rob_chk #(.NUM_RD(NUM_RD)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_ready      (iss_ready),
    .buf_full       (buf_full),
    .buf_empty      (buf_empty),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .exc_valid      (exc_valid),
    .rf_we          (rf_we),
    .st_valid       (st_valid),
    .op_from_rob    (op_from_rob)
);

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int AREGS = 16;
    localparam int EXC_W = 4;
    localparam int NUM_RD = 2;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AREG_W = $clog2(AREGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_rs_free = 1'b1;
    logic [1:0] iss_kind = '0;
    logic [AREG_W-1:0] iss_dest = '0;
    logic [ADDR_W-1:0] iss_pc = '0;
    logic iss_ready;
    logic [IDX_W-1:0] iss_tag;
    logic rb_valid = 1'b0;
    logic [IDX_W-1:0] rb_tag = '0;
    logic [DATA_W-1:0] rb_value = '0;
    logic [ADDR_W-1:0] rb_aux = '0;
    logic rb_mispredict = 1'b0;
    logic [EXC_W-1:0] rb_exc = '0;
    logic [NUM_RD-1:0][AREG_W-1:0] op_reg = '0;
    logic [NUM_RD-1:0] op_from_rob, op_ready;
    logic [NUM_RD-1:0][IDX_W-1:0] op_tag;
    logic [NUM_RD-1:0][DATA_W-1:0] op_value;
    logic rf_we, st_valid, flush, redirect_valid, exc_valid;
    logic [AREG_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata, st_data;
    logic [ADDR_W-1:0] st_addr, redirect_pc, exc_pc;
    logic [EXC_W-1:0] exc_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AREGS(AREGS),
               .EXC_W(EXC_W), .NUM_RD(NUM_RD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_rs_free(iss_rs_free), .iss_kind(iss_kind),
        .iss_dest(iss_dest), .iss_pc(iss_pc), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_value(rb_value), .rb_aux(rb_aux),
        .rb_mispredict(rb_mispredict), .rb_exc(rb_exc),
        .op_reg(op_reg), .op_from_rob(op_from_rob), .op_ready(op_ready),
        .op_tag(op_tag), .op_value(op_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .flush(flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc)
    );

    typedef struct {
        int kind;      // 0 reg write, 1 store, 2 redirect, 3 exception
        longint a;
        longint d;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_errors = 0;
    int retired = 0;
    bit finished = 1'b0;
    longint arch_rf [AREGS];
    longint ref_rf [AREGS];

    task automatic chk(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_item(input int k, input longint a, input longint d);
        exp_t e;
        e.kind = k; e.a = a; e.d = d;
        exp_q.push_back(e);
        if (k == 0) ref_rf[a] = d;
    endtask

    task automatic pop_cmp(input string req, input int k, input longint a, input longint d);
        exp_t e;
        if (exp_q.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL %s unexpected event kind=%0d actual=%0h/%0h expected=none", req, k, a, d);
        end else begin
            e = exp_q.pop_front();
            chk(req, k, e.kind);
            chk(req, a, e.a);
            chk(req, d, e.d);
        end
    endtask

    // monitor: retirement outputs depend only on registered state
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we) begin
                retired++;
                arch_rf[rf_waddr] = longint'(rf_wdata);
                pop_cmp("R5", 0, longint'(rf_waddr), longint'(rf_wdata));
            end
            if (st_valid) begin
                retired++;
                pop_cmp("R5", 1, longint'(st_addr), longint'(st_data));
            end
            if (redirect_valid) pop_cmp("R7", 2, longint'(redirect_pc), 0);
            if (exc_valid)      pop_cmp("R8", 3, longint'(exc_pc), longint'(exc_code));
        end
    end

    task automatic issue(input int k, input int dest, input int pc, output int tag);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_kind  = 2'(k);
        iss_dest  = AREG_W'(dest);
        iss_pc    = ADDR_W'(pc);
        #1;
        chk("R1 issue accepted", longint'(iss_ready), 1);
        tag = int'(iss_tag);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int val, input int aux, input bit mp, input int ex);
        @(negedge clk);
        rb_valid = 1'b1;
        rb_tag = IDX_W'(tag);
        rb_value = DATA_W'(val);
        rb_aux = ADDR_W'(aux);
        rb_mispredict = mp;
        rb_exc = EXC_W'(ex);
        @(negedge clk);
        rb_valid = 1'b0;
        rb_mispredict = 1'b0;
        rb_exc = '0;
    endtask

    task automatic look(input int r0, input int r1);
        op_reg[0] = AREG_W'(r0);
        op_reg[1] = AREG_W'(r1);
        #1;
    endtask

    initial begin
        int t[8];
        int tb_;
        for (int i = 0; i < AREGS; i++) begin arch_rf[i] = 0; ref_rf[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        look(1, 5);
        chk("R10 ready after reset", longint'(iss_ready), 1);
        chk("R10 no write after reset", longint'(rf_we | st_valid | flush), 0);
        chk("R10 lookup empty", longint'(op_from_rob), 0);
        rst_n = 1'b1;

        // R1: no reservation station blocks issue
        @(negedge clk);
        iss_rs_free = 1'b0;
        #1;
        chk("R1 rs busy stalls", longint'(iss_ready), 0);
        iss_rs_free = 1'b1;

        // phase B: four instructions, out-of-order completion
        issue(0, 1, 'h1000, t[0]);
        issue(1, 2, 'h1004, t[1]);
        issue(2, 0, 'h1008, t[2]);
        issue(0, 1, 'h100c, t[3]);
        chk("R1 tag0", t[0], 0); chk("R1 tag1", t[1], 1);
        chk("R1 tag2", t[2], 2); chk("R1 tag3", t[3], 3);
        expect_item(0, 1, 'h11);
        expect_item(0, 2, 'h22);
        expect_item(1, 'h100, 'h33);
        expect_item(0, 1, 'h44);
        look(1, 5);
        chk("R3 pending from rob", longint'(op_from_rob[0]), 1);
        chk("R3 pending not ready", longint'(op_ready[0]), 0);
        chk("R3 newest writer tag", longint'(op_tag[0]), 3);
        chk("R3 idle reg from rf", longint'(op_from_rob[1]), 0);
        chk("R3 idle reg ready", longint'(op_ready[1]), 1);
        bcast(t[3], 'h44, 0, 0, 0);
        look(1, 5);
        chk("R2 forwarded ready", longint'(op_ready[0]), 1);
        chk("R2 forwarded value", longint'(op_value[0]), 'h44);
        bcast(t[1], 'h22, 0, 0, 0);
        bcast(t[2], 'h33, 'h100, 0, 0);
        chk("R4 nothing retires before oldest", retired, 0);
        bcast(t[0], 'h11, 0, 0, 0);
        @(negedge clk);
        #1;
        look(1, 5);
        chk("R6 younger writer kept", longint'(op_from_rob[0]), 1);
        chk("R6 younger writer tag", longint'(op_tag[0]), 3);
        repeat (5) @(negedge clk);
        #1;
        look(1, 2);
        chk("R6 released after last writer", longint'(op_from_rob[0]), 0);
        chk("R4 all retired", retired, 4);

        // phase C: fill and wrap
        for (int i = 0; i < DEPTH; i++) begin
            issue(0, 8 + i, 'h1100 + 4*i, t[i]);
            expect_item(0, 8 + i, 'h500 + i);
        end
        for (int i = 0; i < DEPTH; i++) chk("R1 wrap tag", t[i], (4 + i) % DEPTH);
        #1;
        chk("R1 full stalls", longint'(iss_ready), 0);
        for (int i = DEPTH - 1; i >= 0; i--) bcast(t[i], 'h500 + i, 0, 0, 0);
        repeat (DEPTH + 3) @(negedge clk);

        // phase D: mispredicted branch
        issue(0, 3, 'h2000, t[0]);
        issue(3, 0, 'h2004, t[1]);
        issue(0, 4, 'h2008, t[2]);
        issue(2, 0, 'h200c, t[3]);
        expect_item(0, 3, 'h77);
        expect_item(2, 'h2400, 0);
        bcast(t[2], 'h99, 0, 0, 0);
        bcast(t[3], 'h98, 'h300, 0, 0);
        bcast(t[1], 0, 'h2400, 1, 0);
        bcast(t[0], 'h77, 0, 0, 0);
        do @(negedge clk); while (!flush);
        iss_valid = 1'b1; iss_kind = 2'd0; iss_dest = 4'd6; iss_pc = 'h2010;
        #1;
        chk("R9 issue blocked during flush", longint'(iss_ready), 0);
        @(negedge clk);
        iss_valid = 1'b0;
        #1;
        look(6, 4);
        chk("R9 blocked issue left no trace", longint'(op_from_rob[0]), 0);
        chk("R7 younger writer discarded", longint'(op_from_rob[1]), 0);
        chk("R7 tags restart", longint'(iss_tag), 0);
        repeat (4) @(negedge clk);

        // phase E: faulting load
        issue(0, 5, 'h3000, t[0]);
        issue(1, 6, 'h3004, t[1]);
        issue(0, 7, 'h3008, t[2]);
        expect_item(0, 5, 'h55);
        expect_item(3, 'h3004, 5);
        bcast(t[2], 'h66, 0, 0, 0);
        bcast(t[1], 'h12, 0, 0, 5);
        look(7, 6);
        chk("R8 fault held in slot", retired, 4 + DEPTH + 1);
        bcast(t[0], 'h55, 0, 0, 0);
        do @(negedge clk); while (!exc_valid);
        @(negedge clk);
        #1;
        look(6, 7);
        chk("R8 faulting writer discarded", longint'(op_from_rob[0]), 0);
        chk("R8 younger discarded", longint'(op_from_rob[1]), 0);

        // phase F: resume from the faulting instruction
        issue(1, 6, 'h3004, tb_);
        chk("R8 tags restart", tb_, 0);
        expect_item(0, 6, 'h12);
        bcast(tb_, 'h12, 0, 0, 0);
        repeat (4) @(negedge clk);

        chk("R5 scoreboard drained", exp_q.size(), 0);
        for (int r = 0; r < AREGS; r++) chk("R5 register file vs sequential", arch_rf[r], ref_rf[r]);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule